// File: doc/BRIEF.md
# Multi-core interrupt distribution unit

This block is the shared interrupt controller of a small multiprocessor. It holds a parameterised set of common interrupt lines. For each line it keeps a set of target CPUs, a destination mode, a trigger mode, and a per-CPU pending and acknowledged state. It drives one interrupt output per CPU, together with a local vector number for each CPU. Software reaches all of this through two registers on a simple write bus. One is a command register, which takes a line number and an opcode. The other is a 32-bit parameter register, which carries the operands of write commands and the results of read commands.

A line fires when software asserts it by command, or when its hardware source input triggers. On firing, the line marks one or more CPUs as pending. Which CPUs depends on the destination mode: the lowest CPU in the mask, every CPU in the mask, or the next CPU in a rotating round-robin order. When a CPU takes its interrupt, the line moves from pending to acknowledged for that CPU. It stays acknowledged until software clears the line.

Top module: `irq_dist_unit`

## Requirements
- R1: A bus write with `bus_sel`=0 loads a command word, with the opcode in bits 7:0 and the line number in bits 15:8. The command executes on the next clock edge. A read command loads the parameter register on that same edge, so the old parameter value stays visible for one cycle after the command write.
- R2: Reset leaves the unit globally disabled, with every line in destination mode 0 and the parameter register at 0. Opcode 0x00 disables and opcode 0x01 enables. While disabled, every `cpu_irq` is 0, but pending state is still recorded and appears on the outputs once the unit is enabled.
- R3: Opcode 0x04 writes the line's mode from the parameter register: bit 15 is the trigger (0 level, 1 pulse) and bits 7:0 are the destination (0 off, 1 round-robin, 2 first, 3 all). A destination above 3 is stored as 0. Opcode 0x08 reads the mode back in the same layout.
- R4: Opcode 0x09 stores the low NUM_CPUS bits of the parameter register as the line's target mask. Opcode 0x0A reads the mask back, zero-extended.
- R5: A line in destination mode 0 delivers to no CPU when it is asserted.
- R6: Destination mode 2 delivers only to the lowest-numbered CPU in the target mask.
- R7: Destination mode 3 delivers to every CPU in the target mask.
- R8: Destination mode 1 delivers to the first CPU of the mask at or after the line's rotating pointer, which starts at 0 after reset. The pointer then moves to the next mask CPU after the recipient, wrapping around. Opcode 0x05 returns a status word: bit 0 is global enable, bit 1 is any pending, bit 2 is any acknowledged, and bits 15:8 hold the pointer.
- R9: Opcode 0x03 asserts a line. A `cpu_take` pulse on a CPU whose `cpu_irq` is high moves the line shown on that CPU's `cpu_vec` from pending to acknowledged for that CPU. Opcodes 0x07 and 0x06 return the line's pending and acknowledged CPU bitmasks. A take while `cpu_irq` is low has no effect.
- R10: Opcode 0x02 clears the line's pending and acknowledged state for all CPUs. It wins over a delivery or take in the same cycle.
- R11: `cpu_vec` for each CPU carries 16 plus the lowest line number pending for that CPU.
- R12: In pulse trigger mode, a rising edge on the line's `irq_src` bit delivers once. Holding the source high delivers nothing further.
- R13: In level trigger mode, a high `irq_src` delivers whenever the line has no pending and no acknowledged CPU, so the line redelivers after a clear while the source is still high.
- R14: A line command whose line number is NUM_LINES or above changes nothing, and its reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | 0 selects the command register, 1 selects the parameter register |
| bus_wdata | input | 32 | Write data |
| param_rd | output | 32 | Current parameter register value |
| irq_src | input | NUM_LINES | Hardware source of each common line |
| cpu_take | input | NUM_CPUS | Per-CPU interrupt-taken pulse |
| cpu_irq | output | NUM_CPUS | Per-CPU interrupt request |
| cpu_vec | output | NUM_CPUS*VEC_W | Per-CPU local vector, 16 plus line number |

## Verification
A wrong routing choice or a stale round-robin pointer shows up on the pending bitmask read two cycles after the assert command, and on `cpu_irq` one cycle after it. Lost acknowledge or clear state shows up on the next pending or acknowledge read, or as a missing redelivery on a level line one cycle after the clear. A wrong lowest-line choice appears at once on `cpu_vec`. The bench pairs directed corner cases with seeded random target masks on a round-robin line, and predicts each recipient and pointer value with its own functions.

// File: rtl/idu_pkg.sv
package idu_pkg;

   typedef enum logic [7:0] {
      OP_DISABLE = 8'h00,
      OP_ENABLE  = 8'h01,
      OP_CLEAR   = 8'h02,
      OP_ASSERT  = 8'h03,
      OP_WMODE   = 8'h04,
      OP_STATUS  = 8'h05,
      OP_ACK     = 8'h06,
      OP_PEND    = 8'h07,
      OP_RMODE   = 8'h08,
      OP_WMASK   = 8'h09,
      OP_RMASK   = 8'h0A
   } idu_op_e;

   typedef enum logic [1:0] {
      DST_OFF   = 2'd0,
      DST_RR    = 2'd1,
      DST_FIRST = 2'd2,
      DST_ALL   = 2'd3
   } idu_dst_e;

   localparam int LOCAL_BASE = 16;

endpackage

// File: rtl/idu_cmd_port.sv
module idu_cmd_port (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic        bus_sel,
   input  logic [31:0] bus_wdata,
   input  logic        rd_load,
   input  logic [31:0] rd_data,
   output logic        exec_valid,
   output logic [7:0]  exec_op,
   output logic [7:0]  exec_line,
   output logic [31:0] param_q
);
   logic [15:0] cmd_q;
   logic        cmd_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_vld <= 1'b0;
         cmd_q   <= '0;
         param_q <= '0;
      end else begin
         cmd_vld <= bus_wr & ~bus_sel;
         if (bus_wr && !bus_sel) cmd_q <= bus_wdata[15:0];
         if (rd_load) param_q <= rd_data;
         else if (bus_wr && bus_sel) param_q <= bus_wdata;
      end
   end

   assign exec_valid = cmd_vld;
   assign exec_op    = cmd_q[7:0];
   assign exec_line  = cmd_q[15:8];

   // a command executes exactly one edge after its bus write
   assert_cmd_one_shot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_sel) |=> exec_valid);
endmodule

// File: rtl/idu_line.sv
module idu_line
   import idu_pkg::*;
#(
   parameter int NUM_CPUS = 4,
   localparam int PTR_W   = $clog2(NUM_CPUS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mode_we,
   input  logic                mode_trig,
   input  logic [7:0]          mode_dst,
   input  logic                mask_we,
   input  logic [NUM_CPUS-1:0] mask_in,
   input  logic                sw_assert,
   input  logic                sw_clear,
   input  logic                src,
   input  logic [NUM_CPUS-1:0] take,
   output logic [NUM_CPUS-1:0] pend_q,
   output logic [NUM_CPUS-1:0] ack_q,
   output logic [NUM_CPUS-1:0] mask_q,
   output idu_dst_e            dst_q,
   output logic                trig_q,
   output logic [PTR_W-1:0]    ptr_q
);
   logic                src_d;
   logic                inflight, hw_evt, evt;
   logic [NUM_CPUS-1:0] sel;
   logic [PTR_W-1:0]    pick, nxt;

   assign inflight = (|pend_q) | (|ack_q);
   assign hw_evt   = (dst_q != DST_OFF) &&
                     (trig_q ? (src && !src_d) : (src && !inflight));
   assign evt      = sw_assert | hw_evt;

   // recipient choice for every destination mode
   always_comb begin
      int  idx;
      logic hit, hit2;
      pick = '0;
      nxt  = '0;
      hit  = 1'b0;
      hit2 = 1'b0;
      for (int i = 0; i < NUM_CPUS; i++) begin
         idx = int'(ptr_q) + i;
         if (idx >= NUM_CPUS) idx = idx - NUM_CPUS;
         if (!hit && mask_q[idx]) begin
            hit  = 1'b1;
            pick = PTR_W'(idx);
         end
      end
      for (int i = 1; i <= NUM_CPUS; i++) begin
         idx = int'(pick) + i;
         if (idx >= NUM_CPUS) idx = idx - NUM_CPUS;
         if (!hit2 && mask_q[idx]) begin
            hit2 = 1'b1;
            nxt  = PTR_W'(idx);
         end
      end
      sel = '0;
      case (dst_q)
         DST_ALL:   sel = mask_q;
         DST_FIRST: sel = mask_q & (~mask_q + NUM_CPUS'(1));
         DST_RR:    if (hit) sel = NUM_CPUS'(1) << pick;
         default:   sel = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_d  <= 1'b0;
         pend_q <= '0;
         ack_q  <= '0;
         mask_q <= '0;
         dst_q  <= DST_OFF;
         trig_q <= 1'b0;
         ptr_q  <= '0;
      end else begin
         src_d <= src;
         if (mode_we) begin
            trig_q <= mode_trig;
            dst_q  <= (mode_dst > 8'd3) ? DST_OFF : idu_dst_e'(mode_dst[1:0]);
         end
         if (mask_we) mask_q <= mask_in;
         if (sw_clear) begin
            pend_q <= '0;
            ack_q  <= '0;
         end else begin
            pend_q <= (pend_q & ~take) | (evt ? sel : '0);
            ack_q  <= ack_q | (take & pend_q);
         end
         if (evt && dst_q == DST_RR && (|mask_q)) ptr_q <= nxt;
      end
   end

   assert_take_acks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_clear && |(take & pend_q)) |=> ((ack_q & $past(take & pend_q)) == $past(take & pend_q)));
   assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clear |=> (pend_q == '0 && ack_q == '0));
   assert_first_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && dst_q == DST_FIRST) |-> ($countones(sel) <= 1));
   assert_sel_in_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
      evt |-> ((sel & ~mask_q) == '0));
   assert_ptr_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ptr_q) < NUM_CPUS);
endmodule

// File: rtl/idu_cpu_port.sv
module idu_cpu_port #(
   parameter int NUM_LINES = 32,
   localparam int LINE_W   = $clog2(NUM_LINES)
) (
   input  logic [NUM_LINES-1:0] pend_col,
   input  logic                 enable,
   output logic                 irq,
   output logic [LINE_W-1:0]    line_idx
);
   always_comb begin
      line_idx = '0;
      for (int l = NUM_LINES - 1; l >= 0; l--) begin
         if (pend_col[l]) line_idx = LINE_W'(l);
      end
   end

   assign irq = enable & (|pend_col);
endmodule

// File: rtl/irq_dist_unit.sv
module irq_dist_unit
   import idu_pkg::*;
#(
   parameter int NUM_LINES = 32,
   parameter int NUM_CPUS  = 4,
   localparam int LINE_W   = $clog2(NUM_LINES),
   localparam int PTR_W    = $clog2(NUM_CPUS),
   localparam int VEC_W    = $clog2(NUM_LINES + LOCAL_BASE)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_wr,
   input  logic                      bus_sel,
   input  logic [31:0]               bus_wdata,
   output logic [31:0]               param_rd,
   input  logic [NUM_LINES-1:0]      irq_src,
   input  logic [NUM_CPUS-1:0]       cpu_take,
   output logic [NUM_CPUS-1:0]       cpu_irq,
   output logic [NUM_CPUS*VEC_W-1:0] cpu_vec
);
   if (NUM_LINES < 8 || NUM_LINES > 256) begin : g_bad_lines
      $error("NUM_LINES must lie in 8..256");
   end
   if (NUM_CPUS < 2 || NUM_CPUS > 8) begin : g_bad_cpus
      $error("NUM_CPUS must lie in 2..8");
   end

   logic        exec_valid, rd_load, en_q, line_ok;
   logic [7:0]  exec_op, exec_line;
   logic [31:0] rd_data;
   logic [LINE_W-1:0] lidx;

   logic [NUM_CPUS-1:0] pend_a [NUM_LINES];
   logic [NUM_CPUS-1:0] ack_a  [NUM_LINES];
   logic [NUM_CPUS-1:0] mask_a [NUM_LINES];
   idu_dst_e            dst_a  [NUM_LINES];
   logic                trig_a [NUM_LINES];
   logic [PTR_W-1:0]    ptr_a  [NUM_LINES];
   logic [LINE_W-1:0]   line_of [NUM_CPUS];
   logic [NUM_LINES-1:0] col   [NUM_CPUS];
   logic [NUM_CPUS-1:0] take_ok;

   idu_cmd_port u_cmd (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
      .bus_wdata(bus_wdata), .rd_load(rd_load), .rd_data(rd_data),
      .exec_valid(exec_valid), .exec_op(exec_op), .exec_line(exec_line),
      .param_q(param_rd)
   );

   assign line_ok = int'(exec_line) < NUM_LINES;
   assign lidx    = exec_line[LINE_W-1:0];
   assign take_ok = cpu_take & cpu_irq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else if (exec_valid && exec_op == OP_ENABLE) en_q <= 1'b1;
      else if (exec_valid && exec_op == OP_DISABLE) en_q <= 1'b0;
   end

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      logic                hit;
      logic [NUM_CPUS-1:0] tk;
      assign hit = exec_valid && line_ok && (int'(lidx) == l);
      for (genvar c = 0; c < NUM_CPUS; c++) begin : g_tk
         assign tk[c] = take_ok[c] && (int'(line_of[c]) == l);
      end
      idu_line #(.NUM_CPUS(NUM_CPUS)) u_line (
         .clk(clk), .rst_n(rst_n),
         .mode_we(hit && exec_op == OP_WMODE),
         .mode_trig(param_rd[15]), .mode_dst(param_rd[7:0]),
         .mask_we(hit && exec_op == OP_WMASK),
         .mask_in(param_rd[NUM_CPUS-1:0]),
         .sw_assert(hit && exec_op == OP_ASSERT),
         .sw_clear(hit && exec_op == OP_CLEAR),
         .src(irq_src[l]), .take(tk),
         .pend_q(pend_a[l]), .ack_q(ack_a[l]), .mask_q(mask_a[l]),
         .dst_q(dst_a[l]), .trig_q(trig_a[l]), .ptr_q(ptr_a[l])
      );
   end

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
      always_comb begin
         for (int l = 0; l < NUM_LINES; l++) col[c][l] = pend_a[l][c];
      end
      idu_cpu_port #(.NUM_LINES(NUM_LINES)) u_port (
         .pend_col(col[c]), .enable(en_q),
         .irq(cpu_irq[c]), .line_idx(line_of[c])
      );
      assign cpu_vec[c*VEC_W +: VEC_W] = VEC_W'(LOCAL_BASE) + VEC_W'(line_of[c]);

      assert_vec_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
         cpu_irq[c] |-> pend_a[line_of[c]][c]);
   end

   // read-back selection
   always_comb begin
      rd_load = 1'b0;
      rd_data = '0;
      if (exec_valid) begin
         case (exec_op)
            OP_STATUS, OP_ACK, OP_PEND, OP_RMODE, OP_RMASK: rd_load = 1'b1;
            default: rd_load = 1'b0;
         endcase
         if (line_ok) begin
            case (exec_op)
               OP_STATUS: rd_data = {16'b0, 8'(ptr_a[lidx]), 5'b0,
                                     |ack_a[lidx], |pend_a[lidx], en_q};
               OP_ACK:    rd_data = 32'(ack_a[lidx]);
               OP_PEND:   rd_data = 32'(pend_a[lidx]);
               OP_RMODE:  rd_data = {16'b0, trig_a[lidx], 13'b0, 2'(dst_a[lidx])};
               OP_RMASK:  rd_data = 32'(mask_a[lidx]);
               default:   rd_data = '0;
            endcase
         end
      end
   end

   assert_disable_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_valid && exec_op == OP_DISABLE) |=> (cpu_irq == '0));
endmodule

// File: tb/sim_irq_dist_unit.sv
module sim_irq_dist_unit;
   localparam int NL = 32;
   localparam int NC = 4;
   localparam int VW = $clog2(NL + 16);
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0, bus_sel = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] param_rd;
   logic [NL-1:0] irq_src = '0;
   logic [NC-1:0] cpu_take = '0;
   logic [NC-1:0] cpu_irq;
   logic [NC*VW-1:0] cpu_vec;

   int checks = 0, failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_dist_unit #(.NUM_LINES(NL), .NUM_CPUS(NC)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
      .bus_wdata(bus_wdata), .param_rd(param_rd), .irq_src(irq_src),
      .cpu_take(cpu_take), .cpu_irq(cpu_irq), .cpu_vec(cpu_vec)
   );

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
      end
   endtask

   task automatic cmd(int line, logic [7:0] op);
      @(negedge clk);
      bus_wr = 1'b1; bus_sel = 1'b0; bus_wdata = {16'b0, 8'(line), op};
      @(negedge clk);
      bus_wr = 1'b0;
      @(negedge clk);
   endtask

   task automatic wpar(logic [31:0] v);
      @(negedge clk);
      bus_wr = 1'b1; bus_sel = 1'b1; bus_wdata = v;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic setw(int line, logic [7:0] op, logic [31:0] v);
      wpar(v);
      cmd(line, op);
   endtask

   task automatic take(int c);
      @(negedge clk);
      cpu_take[c] = 1'b1;
      @(negedge clk);
      cpu_take = '0;
   endtask

   function automatic int rr_pick(int m, int p);
      for (int i = 0; i < NC; i++) if (m[(p + i) % NC]) return (p + i) % NC;
      return 0;
   endfunction

   function automatic int rr_next(int m, int k);
      for (int i = 1; i <= NC; i++) if (m[(k + i) % NC]) return (k + i) % NC;
      return k;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int ptr;
      int m, exp;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 reset state
      chk("R2 irq after reset", 32'(cpu_irq), 0);
      chk("R2 param after reset", param_rd, 0);
      cmd(5, 8'h08); chk("R2 mode after reset", param_rd, 0);
      cmd(0, 8'h05); chk("R2 status disabled", param_rd, 0);

      // R3 mode layout
      setw(5, 8'h04, 32'h0000_8003);
      cmd(5, 8'h08); chk("R3 mode readback", param_rd, 32'h8003);
      setw(5, 8'h04, 32'h0000_0009);
      cmd(5, 8'h08); chk("R3 illegal dst stored off", param_rd, 0);
      setw(5, 8'h04, 32'h0000_8003);

      // R1 read lands one edge after the command write
      wpar(32'h1234);
      @(negedge clk); bus_wr = 1'b1; bus_sel = 1'b0; bus_wdata = 32'h0000_0508;
      @(negedge clk); bus_wr = 1'b0;
      chk("R1 param held during capture", param_rd, 32'h1234);
      @(negedge clk);
      chk("R1 read result next edge", param_rd, 32'h8003);

      // R4 mask
      setw(5, 8'h09, 32'h0000_000A);
      cmd(5, 8'h0A); chk("R4 mask readback", param_rd, 32'hA);
      setw(5, 8'h09, 32'hFFFF_FFFF);
      cmd(5, 8'h0A); chk("R4 mask width", param_rd, 32'hF);

      // R2/R7 pending while disabled, broadcast
      setw(3, 8'h04, 32'h3);
      setw(3, 8'h09, 32'h5);
      cmd(3, 8'h03);
      chk("R2 gated while disabled", 32'(cpu_irq), 0);
      cmd(3, 8'h07); chk("R7 broadcast pending", param_rd, 32'h5);
      cmd(3, 8'h05); chk("R8 status pend bit", param_rd, 32'h2);
      cmd(0, 8'h01);
      chk("R2 outputs after enable", 32'(cpu_irq), 32'h5);
      chk("R11 vec cpu0", 32'(cpu_vec[0 +: VW]), 19);

      // R9 take then R10 clear
      take(0);
      chk("R9 irq drops on take", 32'(cpu_irq), 32'h4);
      take(1);
      chk("R9 take without irq ignored", 32'(cpu_irq), 32'h4);
      cmd(3, 8'h07); chk("R9 pending after take", param_rd, 32'h4);
      cmd(3, 8'h06); chk("R9 ack after take", param_rd, 32'h1);
      take(2);
      cmd(3, 8'h06); chk("R9 ack both", param_rd, 32'h5);
      cmd(3, 8'h05); chk("R9 status ack bit", param_rd, 32'h5);
      cmd(3, 8'h02);
      cmd(3, 8'h06); chk("R10 ack cleared", param_rd, 0);
      cmd(3, 8'h07); chk("R10 pend cleared", param_rd, 0);

      // R5 mode off
      setw(2, 8'h09, 32'hF);
      cmd(2, 8'h03);
      cmd(2, 8'h07); chk("R5 off line delivers nothing", param_rd, 0);
      chk("R5 no irq", 32'(cpu_irq), 0);

      // R6 first recipient, R11 lowest line
      setw(4, 8'h04, 32'h2);
      setw(4, 8'h09, 32'hC);
      cmd(4, 8'h03);
      cmd(4, 8'h07); chk("R6 first recipient", param_rd, 32'h4);
      setw(7, 8'h04, 32'h3);
      setw(7, 8'h09, 32'h4);
      cmd(7, 8'h03);
      chk("R11 vec lowest line", 32'(cpu_vec[2*VW +: VW]), 20);
      cmd(0, 8'h00);
      chk("R2 disable masks outputs", 32'(cpu_irq), 0);
      cmd(0, 8'h01);
      take(2);
      chk("R11 vec next line", 32'(cpu_vec[2*VW +: VW]), 23);
      cmd(4, 8'h02); cmd(7, 8'h02);
      chk("R10 all clear", 32'(cpu_irq), 0);

      // R8 round-robin: directed then random masks
      ptr = 0;
      setw(6, 8'h04, 32'h1);
      for (int it = 0; it < 44; it++) begin
         m = (it < 4) ? 32'hB : int'($urandom % 15) + 1;
         setw(6, 8'h09, 32'(m));
         cmd(6, 8'h03);
         exp = rr_pick(m, ptr);
         ptr = rr_next(m, exp);
         cmd(6, 8'h07); chk("R8 rr recipient", param_rd, 32'(1 << exp));
         cmd(6, 8'h05); chk("R8 rr pointer status", param_rd, 32'((ptr << 8) | 3));
         cmd(6, 8'h02);
      end

      // R12 pulse trigger
      setw(8, 8'h04, 32'h8003);
      setw(8, 8'h09, 32'h2);
      @(negedge clk); irq_src[8] = 1'b1;
      @(negedge clk);
      chk("R12 pulse delivers", 32'(cpu_irq), 32'h2);
      take(1);
      cmd(8, 8'h07); chk("R12 held source no repeat", param_rd, 0);
      cmd(8, 8'h02);
      @(negedge clk);
      cmd(8, 8'h07); chk("R12 no redeliver after clear", param_rd, 0);
      irq_src[8] = 1'b0;

      // R13 level trigger
      setw(9, 8'h04, 32'h3);
      setw(9, 8'h09, 32'h1);
      @(negedge clk); irq_src[9] = 1'b1;
      @(negedge clk);
      chk("R13 level delivers", 32'(cpu_irq), 32'h1);
      take(0);
      cmd(9, 8'h07); chk("R13 no repeat while acked", param_rd, 0);
      cmd(9, 8'h02);
      @(negedge clk);
      cmd(9, 8'h07); chk("R13 redeliver after clear", param_rd, 32'h1);
      cmd(9, 8'h06); chk("R13 ack empty after clear", param_rd, 0);
      irq_src[9] = 1'b0;
      cmd(9, 8'h02);
      @(negedge clk);
      cmd(9, 8'h07); chk("R13 quiet after source low", param_rd, 0);

      // R14 out-of-range line
      setw(40, 8'h09, 32'hF);
      cmd(40, 8'h0A); chk("R14 out-of-range read", param_rd, 0);
      cmd(40, 8'h03);
      chk("R14 out-of-range assert ignored", 32'(cpu_irq), 0);
      cmd(8, 8'h0A); chk("R14 neighbour mask untouched", param_rd, 32'h2);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule